// File: doc/BRIEF.md
# Debug Clock Switch Controller

This block chooses the clock that drives a processor core. In normal running the core takes the free-running memory clock. When a debug session starts, the core moves to a debug clock whose pulses come from the JTAG test clock. When serial test patterns are applied, the core also runs from the debug clock, and its pulses are then gated by the TAP controller's state and instruction. The chosen clock is also driven out on a separate pin for the rest of the system.

Both clocks are modelled as levels that are synchronous to one fast reference clock `clk`, so all selection logic is ordinary synchronous logic. On entry to debug, the block raises an acknowledge while the memory clock is high. It lets that high phase finish, then holds the core clock low for at least one reference cycle before handing over. On the way back to the memory clock, the block waits for a RESTART instruction in Run-Test-Idle. It then holds the core clock low until the memory clock is low, so the core never sees a shortened high phase. While the core is off the memory clock, the memory wait-state request is blocked.

Top module: `dbg_clk_switch`

## Requirements
- R1: After an asynchronous active-low reset, the block is in memory mode: `dbg_ack` is 0, `dclk` is 0, and `core_clk` follows `mclk`.
- R2: In memory mode with `test_mode` low, `dbg_req` sampled while `mclk` is high raises `dbg_ack` one reference cycle later. A request sampled while `mclk` is low does not raise it.
- R3: After `dbg_ack` rises, `core_clk` keeps following `mclk` until `mclk` goes low. `core_clk` then stays low for at least one reference cycle before debug mode begins. In debug mode `core_clk` equals `dclk` and ignores `mclk`.
- R4: `sys_clk` always equals `core_clk`.
- R5: `core_wait` equals `wait_req` in memory mode and while the acknowledge is waiting for `mclk` to fall. It is 0 in every other mode.
- R6: In debug mode, each rising edge of `tck` gives one `dclk` pulse one reference cycle wide, but only when `tap_state` is Run-Test-Idle (default code 4'h1) and `tap_instr` is not RESTART (default code 4'h4).
- R7: In debug mode, RESTART held while in Run-Test-Idle clears `dbg_ack` one cycle later. `core_clk` then stays low until `mclk` is sampled low, and after that it follows `mclk` again.
- R8: In memory mode, `test_mode` sampled high while `mclk` is low enters test mode without raising `dbg_ack`. `test_mode` takes priority over `dbg_req`. While `mclk` is high, the block stays in memory mode.
- R9: In test mode, a rising edge of `tck` gives a one-cycle `dclk` pulse only when all three hold: `tap_state` is Run-Test-Idle, `tap_instr` is INTEST (default code 4'hC), and `scan_chain` is 0. Under EXTEST (default code 4'h0) and every other combination, there is no pulse.
- R10: Test mode is left only when `test_mode` is low and `tap_instr` is RESTART at the same sample. The return to `mclk` then follows the same low-wait as R7.
- R11: In memory mode `dclk` stays 0 whatever `tck`, `tap_state` or `tap_instr` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Memory clock level, synchronous to clk |
| tck | input | 1 | JTAG test clock level, synchronous to clk |
| tap_state | input | 4 | Current TAP controller state code |
| tap_instr | input | 4 | Current TAP instruction code |
| scan_chain | input | 4 | Selected scan chain number |
| dbg_req | input | 1 | Request to enter debug |
| test_mode | input | 1 | Serial test mode select |
| wait_req | input | 1 | Memory wait-state request |
| dclk | output | 1 | Debug clock pulse |
| dbg_ack | output | 1 | Debug acknowledge |
| core_clk | output | 1 | Clock level delivered to the core |
| sys_clk | output | 1 | Copy of the core clock for the system |
| core_wait | output | 1 | Wait request after mode gating |

## Verification
The hardest situation to reach is a mode change that lands in the middle of a memory-clock phase. Examples are an acknowledge raised while `mclk` is still high, or a RESTART seen while `mclk` is high. In those cases only the enforced low gap shows that no runt pulse gets through. The bench moves `mclk` by hand, one reference cycle at a time, around each request and each RESTART. It checks `core_clk` in each of those cycles. It then sweeps every TAP state and instruction code, and four scan-chain numbers, in both debug and test modes, and compares each `dclk` pulse with the gating rule.

// File: rtl/dbg_clk_switch.sv
module dbg_clk_switch #(
  parameter int ST_W = 4,
  parameter int IR_W = 4,
  parameter int CH_W = 4,
  parameter logic [ST_W-1:0] RTI_CODE     = 4'h1,
  parameter logic [IR_W-1:0] RESTART_CODE = 4'h4,
  parameter logic [IR_W-1:0] INTEST_CODE  = 4'hC,
  parameter logic [IR_W-1:0] EXTEST_CODE  = 4'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclk,
  input  logic            tck,
  input  logic [ST_W-1:0] tap_state,
  input  logic [IR_W-1:0] tap_instr,
  input  logic [CH_W-1:0] scan_chain,
  input  logic            dbg_req,
  input  logic            test_mode,
  input  logic            wait_req,
  output logic            dclk,
  output logic            dbg_ack,
  output logic            core_clk,
  output logic            sys_clk,
  output logic            core_wait
);

  typedef enum logic [2:0] {
    M_MEM, M_ACKW, M_GAPIN, M_DBG, M_TEST, M_GAPOUT
  } mode_t;

  mode_t mode, mode_nx;
  logic  tck_q;

  wire in_rti   = (tap_state == RTI_CODE);
  wire restart  = (tap_instr == RESTART_CODE);
  wire test_ok  = in_rti && (tap_instr == INTEST_CODE) && (scan_chain == '0);
  wire dbg_ok   = in_rti && !restart;
  wire tck_rise = tck && !tck_q;
  wire mem_sel  = (mode == M_MEM) || (mode == M_ACKW);
  wire dck_sel  = (mode == M_DBG) || (mode == M_TEST);
  wire gen_en   = ((mode == M_DBG) && dbg_ok) || ((mode == M_TEST) && test_ok);

  always_comb begin
    mode_nx = mode;
    case (mode)
      M_MEM: begin
        if (test_mode) begin
          if (!mclk) mode_nx = M_TEST;
        end else if (dbg_req && mclk) begin
          mode_nx = M_ACKW;
        end
      end
      M_ACKW:   if (!mclk) mode_nx = M_GAPIN;
      M_GAPIN:  mode_nx = M_DBG;
      M_DBG:    if (in_rti && restart) mode_nx = M_GAPOUT;
      M_TEST:   if (!test_mode && restart) mode_nx = M_GAPOUT;
      M_GAPOUT: if (!mclk) mode_nx = M_MEM;
      default:  mode_nx = M_MEM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= M_MEM;
      tck_q <= 1'b0;
      dclk  <= 1'b0;
    end else begin
      mode  <= mode_nx;
      tck_q <= tck;
      dclk  <= gen_en && tck_rise;
    end
  end

  assign dbg_ack   = (mode == M_ACKW) || (mode == M_GAPIN) || (mode == M_DBG);
  assign core_clk  = (mem_sel && mclk) || (dck_sel && dclk);
  assign sys_clk   = core_clk;
  assign core_wait = mem_sel && wait_req;

  assert_ack_in_mclk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_ack) |-> $past(mclk));

  assert_gap_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_GAPIN) || (mode == M_GAPOUT)) |-> !core_clk);

  assert_sys_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk == core_clk);

  assert_wait_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DBG) |-> !core_wait);

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> !dclk);

  assert_exit_on_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbg_ack) |-> $past(tap_instr == RESTART_CODE && tap_state == RTI_CODE));

  assert_test_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk && $past(mode == M_TEST)) |->
      $past(tap_state == RTI_CODE && tap_instr == INTEST_CODE && scan_chain == '0));

  assert_no_extest_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode == M_TEST) && $past(tap_instr == EXTEST_CODE)) |-> !dclk);

  assert_mem_dclk_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode == M_MEM) && (mode == M_MEM)) |-> !dclk);

endmodule

// File: tb/tb_dbg_clk_switch.sv
module tb_dbg_clk_switch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk = 1'b0, tck = 1'b0, dbg_req = 1'b0, test_mode = 1'b0, wait_req = 1'b0;
  logic [3:0] tap_state = 4'h0, tap_instr = 4'h0, scan_chain = 4'h0;
  logic dclk, dbg_ack, core_clk, sys_clk, core_wait;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  localparam logic [3:0] RTI = 4'h1, RST_I = 4'h4, INT_I = 4'hC, EXT_I = 4'h0;

  dbg_clk_switch dut (
    .clk(clk), .rst_n(rst_n), .mclk(mclk), .tck(tck), .tap_state(tap_state),
    .tap_instr(tap_instr), .scan_chain(scan_chain), .dbg_req(dbg_req),
    .test_mode(test_mode), .wait_req(wait_req), .dclk(dclk), .dbg_ack(dbg_ack),
    .core_clk(core_clk), .sys_clk(sys_clk), .core_wait(core_wait));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulse_tck(input logic exp, input string tag);
    tck = 1'b0; tick();
    tck = 1'b1; tick();
    chk(dclk, exp, tag);
    chk(core_clk, exp, {tag, " core_clk"});
    chk(sys_clk, core_clk, "R4 sys_clk copy");
    tck = 1'b0; tick();
    chk(dclk, 1'b0, {tag, " pulse width"});
  endtask

  initial begin
    tick(); tick();
    rst_n = 1'b1; tick();
    chk(dbg_ack, 1'b0, "R1 ack after reset");
    chk(dclk, 1'b0, "R1 dclk after reset");
    mclk = 1'b1; #1 chk(core_clk, 1'b1, "R1 core follows mclk high");
    mclk = 1'b0; #1 chk(core_clk, 1'b0, "R1 core follows mclk low");

    tap_state = RTI; tap_instr = INT_I;
    for (int i = 0; i < 3; i++) begin
      tck = 1'b1; tick(); chk(dclk, 1'b0, "R11 no dclk in memory mode");
      tck = 1'b0; tick(); chk(dclk, 1'b0, "R11 no dclk in memory mode");
    end
    wait_req = 1'b1; #1 chk(core_wait, 1'b1, "R5 wait passes in memory mode");
    wait_req = 1'b0; #1 chk(core_wait, 1'b0, "R5 wait low in memory mode");

    tap_state = 4'h0; tap_instr = 4'h0;
    dbg_req = 1'b1; tick();
    chk(dbg_ack, 1'b0, "R2 no ack while mclk low");
    mclk = 1'b1; tick();
    chk(dbg_ack, 1'b1, "R2 ack after mclk high");
    chk(core_clk, 1'b1, "R3 mclk phase completes");
    wait_req = 1'b1; #1 chk(core_wait, 1'b1, "R5 wait passes during ack wait");
    tick();
    chk(core_clk, 1'b1, "R3 still on mclk high");
    mclk = 1'b0; #1 chk(core_clk, 1'b0, "R3 mclk fall passes");
    tick();
    mclk = 1'b1; #1 chk(core_clk, 1'b0, "R3 gap cycle low");
    chk(core_wait, 1'b0, "R5 wait blocked in gap");
    tick();
    chk(dbg_ack, 1'b1, "R3 in debug");
    chk(core_clk, 1'b0, "R3 debug ignores mclk high");
    chk(core_wait, 1'b0, "R5 wait blocked in debug");
    dbg_req = 1'b0; wait_req = 1'b0;

    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 16; r++) begin
        if (s == RTI && r == RST_I) continue;
        tap_state = 4'(s); tap_instr = 4'(r); scan_chain = 4'(r % 4);
        mclk = ~mclk;
        pulse_tck((4'(s) == RTI) && (4'(r) != RST_I), "R6 debug dclk gating");
      end
    chk(dbg_ack, 1'b1, "R6 still in debug after sweep");

    mclk = 1'b1; tap_state = RTI; tap_instr = RST_I; tick();
    chk(dbg_ack, 1'b0, "R7 ack clears on restart");
    chk(core_clk, 1'b0, "R7 gap while mclk high");
    tap_state = 4'h0; tap_instr = 4'h0;
    tick();
    chk(core_clk, 1'b0, "R7 hold until mclk low");
    mclk = 1'b0; tick();
    mclk = 1'b1; #1 chk(core_clk, 1'b1, "R7 back on mclk");
    wait_req = 1'b1; #1 chk(core_wait, 1'b1, "R5 wait passes again");
    wait_req = 1'b0;

    test_mode = 1'b1; dbg_req = 1'b1; tick();
    chk(dbg_ack, 1'b0, "R8 test beats debug request");
    chk(core_clk, 1'b1, "R8 stays on mclk while high");
    mclk = 1'b0; tick();
    dbg_req = 1'b0;
    mclk = 1'b1; #1 chk(core_clk, 1'b0, "R8 in test mode mclk blocked");
    chk(dbg_ack, 1'b0, "R8 no ack in test mode");

    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 4; c++) begin
          tap_state = 4'(s); tap_instr = 4'(r); scan_chain = 4'(c);
          pulse_tck((4'(s) == RTI) && (4'(r) == INT_I) && (c == 0), "R9 test dclk gating");
        end
    tap_state = RTI; tap_instr = EXT_I; scan_chain = 4'h0;
    pulse_tck(1'b0, "R9 no pulse under EXTEST");

    tap_instr = RST_I; tick(); tick();
    chk(core_clk, 1'b0, "R10 restart alone keeps test");
    test_mode = 1'b0; tap_instr = INT_I; tick(); tick();
    chk(core_clk, 1'b0, "R10 test low alone keeps test");
    pulse_tck(1'b1, "R10 still in test mode");
    tap_instr = RST_I; tick();
    chk(core_clk, 1'b0, "R10 gap on exit");
    mclk = 1'b0; tick();
    mclk = 1'b1; #1 chk(core_clk, 1'b1, "R10 back on mclk");
    chk(sys_clk, 1'b1, "R4 sys_clk copy");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule